// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block decides when a receive path interrupts the host. Each packet that has been completed into host memory arrives as a one-cycle pulse. The block counts these packets and raises a level interrupt once enough of them have gathered, so that one host service pass handles several packets and the host sees fewer interrupts. A hold-off timer bounds the wait. The timer starts when the first unreported packet is seen, and later packets do not restart it. The interrupt therefore fires when either the packet threshold or the timer limit is reached, whichever comes first, and no packet waits for an unbounded time.

The threshold and the delay limit are static inputs that a register stage drives. The host clears the request with an acknowledge pulse. While the request is pending, arriving packets keep adding to the coalesced count, which the host can read as a hint of how much work is waiting. When coalescing is switched off, every packet produces an interrupt at once.

Top module: `rx_irq_moderator`

## Requirements
- R1: After reset, `irq_req` is low and `coalesced_cnt` is 0.
- R2: When `mod_en` is 0, a packet pulse sampled at a clock edge makes `irq_req` high right after that edge, whatever the threshold is.
- R3: When `mod_en` is 1 and `pkt_thresh` is 0 or 1, every packet raises `irq_req` right after the edge that samples it, in the same way as R2.
- R4: When `mod_en` is 1 and `pkt_thresh` is N > 1, a single packet does not raise the interrupt. `irq_req` goes high right after the edge that samples the N-th counted packet, provided the timer has not fired earlier.
- R5: The first packet counted while no interrupt is pending starts the hold-off timer, and later packets do not restart it. If the threshold has not been reached, `irq_req` goes high max(`max_delay`,1) cycles after the edge that sampled that first packet. A `max_delay` of 0 acts as 1.
- R6: Once high, `irq_req` stays high until `irq_ack`. Packets that arrive while the request is pending still add to `coalesced_cnt`.
- R7: An `irq_ack` drops `irq_req` and clears the count and the timer at the same edge. A packet sampled at that same edge is kept as count 1, and it arms a fresh timer.
- R8: `coalesced_cnt` saturates at 2^TALLY_W-1 and does not wrap.
- R9: Each packet pulse without an acknowledge raises `coalesced_cnt` by exactly one, visible right after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_done | input | 1 | One-cycle pulse per packet completed into host memory |
| irq_ack | input | 1 | Host acknowledge; clears the request, the count and the timer |
| mod_en | input | 1 | 1 = coalescing on, 0 = interrupt per packet |
| pkt_thresh | input | TALLY_W | Packet count that triggers the interrupt (0 or 1 = per packet) |
| max_delay | input | DLY_W | Hold-off limit in clock cycles from the first unreported packet |
| irq_req | output | 1 | Level interrupt request |
| coalesced_cnt | output | TALLY_W | Packets gathered since the last acknowledge (saturating) |

## Verification
Count, acknowledge and per-packet interrupt effects all pass through one register, so they are due on the sample point just after the edge that takes in the pulse. A timer interrupt is due max(`max_delay`,1) cycles after that edge, and the sample one cycle earlier must still show the request low. The driver tasks stamp every expectation with the absolute cycle in which it falls due. The monitor compares an expectation only at that cycle's falling edge, and it fails any expectation whose cycle has passed without a match.

// File: rtl/rxim_pkg.sv
package rxim_pkg;

  // saturating increment: stops at lim
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // effective packet threshold: per-packet when off or threshold below 2
  function automatic int unsigned eff_thresh(logic en, int unsigned thr);
    return (!en || thr <= 1) ? 1 : thr;
  endfunction

  // timer reaches its limit on this cycle (limit 0 behaves like 1)
  function automatic logic delay_hit(int unsigned t, int unsigned lim);
    return (t + 1) >= lim;
  endfunction

endpackage

// File: rtl/rxim_tally.sv
module rxim_tally #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pkt,
  input  logic         clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  localparam int unsigned MAXV = (1 << W) - 1;

  always_comb begin
    if (clr)
      cnt_nxt = pkt ? W'(1) : '0;
    else if (pkt)
      cnt_nxt = W'(rxim_pkg::sat_inc(32'(cnt_q), MAXV));
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rxim_holdoff.sv
module rxim_holdoff #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          clr,
  input  logic [DW-1:0] limit,
  output logic          expire
);
  logic [DW-1:0] tmr_q;

  assign expire = armed && rxim_pkg::delay_hit(32'(tmr_q), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !armed) tmr_q <= '0;
    else if (!expire)            tmr_q <= tmr_q + DW'(1);
  end
endmodule

// File: rtl/rxim_flag.sv
module rxim_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic fire,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (ack) irq_q <= 1'b0;
    else if (fire) irq_q <= 1'b1;
  end
endmodule

// File: rtl/rx_irq_moderator.sv
module rx_irq_moderator #(
  parameter int TALLY_W = 8,
  parameter int DLY_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pkt_done,
  input  logic               irq_ack,
  input  logic               mod_en,
  input  logic [TALLY_W-1:0] pkt_thresh,
  input  logic [DLY_W-1:0]   max_delay,
  output logic               irq_req,
  output logic [TALLY_W-1:0] coalesced_cnt
);
  logic [TALLY_W-1:0] cnt_nxt;
  logic               armed;
  logic               fire_cnt;
  logic               fire_tmr;

  rxim_tally #(.W(TALLY_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .pkt(pkt_done), .clr(irq_ack),
    .cnt_q(coalesced_cnt), .cnt_nxt(cnt_nxt)
  );

  // timer runs only while packets wait and nothing is pending
  assign armed = (coalesced_cnt != '0) && !irq_req;

  rxim_holdoff #(.DW(DLY_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .armed(armed), .clr(irq_ack),
    .limit(max_delay), .expire(fire_tmr)
  );

  assign fire_cnt = !irq_req &&
                    (32'(cnt_nxt) >= rxim_pkg::eff_thresh(mod_en, 32'(pkt_thresh)));

  rxim_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ack(irq_ack),
    .fire(fire_cnt || fire_tmr), .irq_q(irq_req)
  );
endmodule

module rxim_checker #(
  parameter int TALLY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_done,
  input logic               irq_ack,
  input logic               mod_en,
  input logic [TALLY_W-1:0] pkt_thresh,
  input logic               irq_req,
  input logic [TALLY_W-1:0] coalesced_cnt,
  input logic               fire_cnt,
  input logic               fire_tmr
);
  localparam logic [TALLY_W-1:0] TOP = '1;

  p_per_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en && pkt_done && !irq_ack |=> irq_req);

  p_no_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en && pkt_thresh > 1 && !irq_req && coalesced_cnt == '0 && !irq_ack |=> !irq_req);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req);

  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && !irq_ack && !fire_cnt && !fire_tmr |=> !irq_req);

  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !pkt_done |=> !irq_req && coalesced_cnt == '0);

  p_ack_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && pkt_done |=> !irq_req && coalesced_cnt == TALLY_W'(1));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coalesced_cnt == TOP && !irq_ack |=> coalesced_cnt == TOP);

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !irq_ack && coalesced_cnt != TOP |=> coalesced_cnt == $past(coalesced_cnt) + TALLY_W'(1));
endmodule

bind rx_irq_moderator rxim_checker #(.TALLY_W(TALLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .irq_ack(irq_ack),
  .mod_en(mod_en), .pkt_thresh(pkt_thresh), .irq_req(irq_req),
  .coalesced_cnt(coalesced_cnt), .fire_cnt(fire_cnt), .fire_tmr(fire_tmr)
);

// File: tb/sim_rx_irq_moderator.sv
module sim_rx_irq_moderator;
  localparam int TW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_done = 1'b0;
  logic irq_ack = 1'b0;
  logic mod_en = 1'b0;
  logic [TW-1:0] pkt_thresh = '0;
  logic [DW-1:0] max_delay = '0;
  logic irq_req;
  logic [TW-1:0] coalesced_cnt;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  typedef struct {
    int    at;
    bit    irq;
    int    cnt;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rx_irq_moderator #(.TALLY_W(TW), .DLY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .irq_ack(irq_ack),
    .mod_en(mod_en), .pkt_thresh(pkt_thresh), .max_delay(max_delay),
    .irq_req(irq_req), .coalesced_cnt(coalesced_cnt)
  );

  // driver side: expectation due dt cycles after the current one
  function automatic void want(int dt, bit irq, int cnt, string tag);
    exp_t e;
    e.at = cyc + dt; e.irq = irq; e.cnt = cnt; e.tag = tag;
    sb.push_back(e);
  endfunction

  // monitor: compare due items away from the active edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at < cyc) begin
        total++; bad++;
        $display("FAIL %s: expectation for cycle %0d never compared", sb[i].tag, sb[i].at);
        sb.delete(i);
      end else if (sb[i].at == cyc) begin
        total++;
        if (irq_req !== sb[i].irq || int'(coalesced_cnt) != sb[i].cnt) begin
          bad++;
          $display("FAIL %s @%0d: irq=%0b cnt=%0d expected irq=%0b cnt=%0d",
                   sb[i].tag, cyc, irq_req, coalesced_cnt, sb[i].irq, sb[i].cnt);
        end
        sb.delete(i);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(bit with_ack);
    pkt_done = 1'b1; irq_ack = with_ack;
    @(negedge clk);
    pkt_done = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic ack_only(string tag);
    want(1, 1'b0, 0, tag);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic finish_run();
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, cycle=%0d expected end", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    want(1, 1'b0, 0, "R1");
    idle(2);

    // R2 coalescing off: per packet, threshold ignored
    mod_en = 1'b0; pkt_thresh = TW'(5); max_delay = DW'(100);
    want(1, 1'b1, 1, "R2");
    pulse(1'b0);
    idle(2);
    ack_only("R7");
    idle(2);

    // R3 threshold 1 and 0 with coalescing on
    mod_en = 1'b1; pkt_thresh = TW'(1);
    want(1, 1'b1, 1, "R3");
    pulse(1'b0);
    ack_only("R7");
    pkt_thresh = TW'(0);
    want(1, 1'b1, 1, "R3");
    pulse(1'b0);
    ack_only("R7");
    idle(2);

    // R4 and R9 threshold of 4, back-to-back packets
    pkt_thresh = TW'(4); max_delay = DW'(1000);
    want(1, 1'b0, 1, "R9");
    want(2, 1'b0, 2, "R4");
    want(3, 1'b0, 3, "R4");
    want(4, 1'b1, 4, "R4");
    for (int i = 0; i < 4; i++) pulse(1'b0);
    idle(2);
    ack_only("R7");
    idle(2);

    // R5 timer bound, not restarted by a later packet
    pkt_thresh = TW'(10); max_delay = DW'(20);
    want(1, 1'b0, 1, "R5");
    want(6, 1'b0, 2, "R5");
    want(20, 1'b0, 2, "R5");
    want(21, 1'b1, 2, "R5");
    pulse(1'b0);
    idle(4);
    pulse(1'b0);
    idle(20);

    // R6 pending request holds and still counts
    want(1, 1'b1, 3, "R6");
    pulse(1'b0);
    idle(3);
    want(0, 1'b1, 3, "R6");
    idle(1);

    // R7 ack with same-cycle packet: kept, timer restarted
    want(1, 1'b0, 1, "R7");
    want(20, 1'b0, 1, "R7");
    want(21, 1'b1, 1, "R7");
    pulse(1'b1);
    idle(22);
    ack_only("R7");
    idle(2);

    // R5 delay limit of 0 acts as 1
    max_delay = DW'(0);
    want(1, 1'b0, 1, "R5");
    want(2, 1'b1, 1, "R5");
    pulse(1'b0);
    idle(2);
    ack_only("R7");
    idle(2);

    // R8 saturation at 255 with top threshold and long delay
    pkt_thresh = TW'(255); max_delay = DW'(65535);
    for (int i = 0; i < 260; i++) begin
      if (i == 253) want(1, 1'b0, 254, "R4");
      if (i == 254) want(1, 1'b1, 255, "R4");
      if (i == 259) want(1, 1'b1, 255, "R8");
      pulse(1'b0);
    end
    idle(2);
    ack_only("R8");

    finish_run();
  end
endmodule